// File: doc/BRIEF.md
# Tag Check Fault Mode Controller

This block takes a reported memory tag check failure and decides what happens to it. A 2-bit fault policy is taken from a 64-bit system control word. Which pair of bits supplies it depends on whether the failing access ran in an unprivileged regime. The policy can drop the failure. It can raise a synchronous exception request, which captures the faulting virtual address and a data-abort syndrome. It can instead set a sticky asynchronous status bit for the exception level involved. A mixed policy traps loads and only flags stores.

Each exception level has two asynchronous status bits, one for each half of a split address space. The bit is picked by address bit 55 when the regime uses two address ranges. Software clears these bits through a clear port. A failure that sets a bit in the same cycle as a clear of that bit wins, so the failure is not lost. Taking the exception is left to the surrounding core.

Top module: `tcf_fault_ctrl`

## Requirements
- R1: The 2-bit policy comes from control bits [39:38] when `flt_unpriv` is 1 and from bits [41:40] otherwise. The other control bits have no effect.
- R2: Policy 0: a failure changes nothing. `sync_req` stays 0, and the status bits and captured address/syndrome keep their values.
- R3: Policy 1: every failure, load or store, raises a synchronous request.
- R4: Policy 2: every failure, load or store, sets an asynchronous status bit and raises no synchronous request.
- R5: Policy 3: a store failure sets an asynchronous status bit. A load failure raises a synchronous request.
- R6: An asynchronous failure at level L sets bit 1 of that level's pair (`async_status[2L+1]`) when `flt_two_range` is 1 and `flt_addr[55]` is 1. Otherwise it sets bit 0 (`async_status[2L]`). Bits accumulate by OR, across levels and within a pair.
- R7: A synchronous failure seen at a clock edge makes `sync_req` 1 for the following cycle only. In the same cycle `sync_vaddr` equals the fault address, `sync_syndrome[5:0]` is 0x11 and `sync_syndrome[6]` is 1 for a store and 0 for a load.
- R8: `sync_vaddr` and `sync_syndrome` hold their values until the next synchronous failure. Asynchronous and ignored failures do not change them.
- R9: When `clr_valid` is 1, the bits of level `clr_level` selected by `clr_mask` are cleared at the next edge. If a failure sets one of those bits in the same cycle, the bit ends up set.
- R10: After synchronous reset `sync_req`, `sync_vaddr`, `sync_syndrome` and `async_status` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flt_valid | input | 1 | One-cycle tag check failure report |
| flt_addr | input | ADDR_W | Virtual address of the failure |
| flt_is_store | input | 1 | 1 for a store access, 0 for a load |
| flt_unpriv | input | 1 | Access ran in an unprivileged regime |
| flt_two_range | input | 1 | Regime splits the address space into two ranges |
| flt_level | input | LVL_W | Exception level whose status pair is used |
| ctrl_word | input | CTRL_W | System control word carrying both policy fields |
| clr_valid | input | 1 | Software clear strobe |
| clr_level | input | LVL_W | Level whose status pair is cleared |
| clr_mask | input | 2 | Bits of the pair to clear |
| sync_req | output | 1 | Synchronous exception request pulse |
| sync_syndrome | output | 7 | {write flag, fault status code} of the last synchronous failure |
| sync_vaddr | output | ADDR_W | Address of the last synchronous failure |
| async_status | output | 2*NUM_LVL | Sticky asynchronous status, two bits per level |

## Verification
A wrong policy decode shows up on the first failure after the control word changes. It appears one cycle later either as an unexpected `sync_req` pulse or as a status bit that is missing or extra. A corrupted status register cannot recover on its own, because the bits are sticky. The error therefore stays visible at the ports until a clear is issued, and the clear-versus-set collision case is driven on purpose. A capture register that updates on the wrong kind of failure is caught on the next cycle: the bench checks the address and syndrome after every operation, not only after synchronous ones.

// File: rtl/tcf_pkg.sv
package tcf_pkg;

    // Policy fields inside the control word
    localparam int UNPRIV_FIELD_LSB = 38;
    localparam int PRIV_FIELD_LSB   = 40;
    // Address bit that selects the upper half of a split address space
    localparam int RANGE_SEL_BIT    = 55;
    // Fault status code reported for a tag check failure
    localparam logic [5:0] TAG_FSC  = 6'h11;

    typedef enum logic [1:0] {
        TCF_IGNORE = 2'd0,
        TCF_TRAP   = 2'd1,
        TCF_FLAG   = 2'd2,
        TCF_MIXED  = 2'd3
    } tcf_mode_e;

    typedef struct packed {
        logic       wnr;
        logic [5:0] fsc;
    } tcf_syn_t;

    typedef struct packed {
        logic       do_sync;
        logic       do_async;
        logic [1:0] async_bits;
    } tcf_action_t;

    function automatic tcf_mode_e pick_mode(input logic [63:0] ctrl, input logic unpriv);
        logic [1:0] f;
        f = unpriv ? ctrl[UNPRIV_FIELD_LSB +: 2] : ctrl[PRIV_FIELD_LSB +: 2];
        return tcf_mode_e'(f);
    endfunction

endpackage

// File: rtl/tcf_mode_select.sv
module tcf_mode_select
    import tcf_pkg::*;
#(
    parameter int CTRL_W = 64
) (
    input  logic [CTRL_W-1:0] ctrl_word,
    input  logic              unpriv,
    output tcf_mode_e         mode
);
    logic [63:0] ctrl_ext;

    generate
        if (CTRL_W >= 64) begin : g_trunc
            assign ctrl_ext = ctrl_word[63:0];
        end else begin : g_pad
            assign ctrl_ext = {{(64-CTRL_W){1'b0}}, ctrl_word};
        end
    endgenerate

    always_comb begin
        mode = pick_mode(ctrl_ext, unpriv);
    end
endmodule

// File: rtl/tcf_policy.sv
module tcf_policy
    import tcf_pkg::*;
#(
    parameter int ADDR_W = 64
) (
    input  logic              valid,
    input  tcf_mode_e         mode,
    input  logic              is_store,
    input  logic              two_range,
    input  logic [ADDR_W-1:0] addr,
    output tcf_action_t       act
);
    logic upper_half;

    assign upper_half = two_range & addr[RANGE_SEL_BIT];

    always_comb begin
        act = '0;
        if (valid) begin
            unique case (mode)
                TCF_IGNORE: ;
                TCF_TRAP:   act.do_sync  = 1'b1;
                TCF_FLAG:   act.do_async = 1'b1;
                TCF_MIXED: begin
                    act.do_async = is_store;
                    act.do_sync  = ~is_store;
                end
                default: ;
            endcase
        end
        if (act.do_async) begin
            act.async_bits = upper_half ? 2'b10 : 2'b01;
        end
    end
endmodule

// File: rtl/tcf_sync_capture.sv
module tcf_sync_capture
    import tcf_pkg::*;
#(
    parameter int ADDR_W = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fire,
    input  logic              is_store,
    input  logic [ADDR_W-1:0] addr,
    output logic              req,
    output tcf_syn_t          syn,
    output logic [ADDR_W-1:0] vaddr
);
    always_ff @(posedge clk) begin
        if (rst) begin
            req   <= 1'b0;
            syn   <= '0;
            vaddr <= '0;
        end else begin
            req <= fire;
            if (fire) begin
                syn.wnr <= is_store;
                syn.fsc <= TAG_FSC;
                vaddr   <= addr;
            end
        end
    end
endmodule

// File: rtl/tcf_async_status.sv
module tcf_async_status #(
    parameter int NUM_LVL = 4,
    parameter int LVL_W   = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 set_en,
    input  logic [LVL_W-1:0]     set_level,
    input  logic [1:0]           set_bits,
    input  logic                 clr_en,
    input  logic [LVL_W-1:0]     clr_level,
    input  logic [1:0]           clr_bits,
    output logic [2*NUM_LVL-1:0] status
);
    genvar g;
    generate
        for (g = 0; g < NUM_LVL; g++) begin : g_lvl
            logic [1:0] pair_q;
            logic [1:0] set_here;
            logic [1:0] clr_here;

            assign set_here = (set_en && set_level == LVL_W'(g)) ? set_bits : 2'b00;
            assign clr_here = (clr_en && clr_level == LVL_W'(g)) ? clr_bits : 2'b00;

            always_ff @(posedge clk) begin
                if (rst) begin
                    pair_q <= 2'b00;
                end else begin
                    // a new failure overrides a clear of the same bit
                    pair_q <= (pair_q & ~clr_here) | set_here;
                end
            end

            assign status[2*g +: 2] = pair_q;
        end
    endgenerate
endmodule

// File: rtl/tcf_fault_ctrl.sv
module tcf_fault_ctrl
    import tcf_pkg::*;
#(
    parameter int ADDR_W  = 64,
    parameter int CTRL_W  = 64,
    parameter int NUM_LVL = 4,
    localparam int LVL_W  = (NUM_LVL > 1) ? $clog2(NUM_LVL) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 flt_valid,
    input  logic [ADDR_W-1:0]    flt_addr,
    input  logic                 flt_is_store,
    input  logic                 flt_unpriv,
    input  logic                 flt_two_range,
    input  logic [LVL_W-1:0]     flt_level,
    input  logic [CTRL_W-1:0]    ctrl_word,
    input  logic                 clr_valid,
    input  logic [LVL_W-1:0]     clr_level,
    input  logic [1:0]           clr_mask,
    output logic                 sync_req,
    output logic [6:0]           sync_syndrome,
    output logic [ADDR_W-1:0]    sync_vaddr,
    output logic [2*NUM_LVL-1:0] async_status
);
    tcf_mode_e   mode;
    tcf_action_t act;
    tcf_syn_t    syn_q;

    tcf_mode_select #(.CTRL_W(CTRL_W)) u_mode (
        .ctrl_word (ctrl_word),
        .unpriv    (flt_unpriv),
        .mode      (mode)
    );

    tcf_policy #(.ADDR_W(ADDR_W)) u_policy (
        .valid     (flt_valid),
        .mode      (mode),
        .is_store  (flt_is_store),
        .two_range (flt_two_range),
        .addr      (flt_addr),
        .act       (act)
    );

    tcf_sync_capture #(.ADDR_W(ADDR_W)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .fire     (act.do_sync),
        .is_store (flt_is_store),
        .addr     (flt_addr),
        .req      (sync_req),
        .syn      (syn_q),
        .vaddr    (sync_vaddr)
    );

    assign sync_syndrome = syn_q;

    tcf_async_status #(.NUM_LVL(NUM_LVL), .LVL_W(LVL_W)) u_async (
        .clk       (clk),
        .rst       (rst),
        .set_en    (act.do_async),
        .set_level (flt_level),
        .set_bits  (act.async_bits),
        .clr_en    (clr_valid),
        .clr_level (clr_level),
        .clr_bits  (clr_mask),
        .status    (async_status)
    );
endmodule

// File: rtl/tcf_fault_ctrl_chk.sv
module tcf_fault_ctrl_chk #(
    parameter int ADDR_W  = 64,
    parameter int CTRL_W  = 64,
    parameter int NUM_LVL = 4,
    parameter int LVL_W   = 2
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 flt_valid,
    input logic [ADDR_W-1:0]    flt_addr,
    input logic                 flt_is_store,
    input logic                 flt_unpriv,
    input logic                 flt_two_range,
    input logic [LVL_W-1:0]     flt_level,
    input logic [CTRL_W-1:0]    ctrl_word,
    input logic                 clr_valid,
    input logic [LVL_W-1:0]     clr_level,
    input logic [1:0]           clr_mask,
    input logic                 sync_req,
    input logic [6:0]           sync_syndrome,
    input logic [ADDR_W-1:0]    sync_vaddr,
    input logic [2*NUM_LVL-1:0] async_status
);
    AST_REQ_NEEDS_FAULT: assert property (@(posedge clk) disable iff (rst)
        sync_req |-> $past(flt_valid)) else $error("request without failure"); // R7

    AST_REQ_CAPTURES_ADDR: assert property (@(posedge clk) disable iff (rst)
        sync_req |-> sync_vaddr == $past(flt_addr)) else $error("address not captured"); // R7

    AST_SYN_CODE: assert property (@(posedge clk) disable iff (rst)
        sync_req |-> (sync_syndrome[5:0] == 6'h11 && sync_syndrome[6] == $past(flt_is_store)))
        else $error("bad syndrome"); // R7

    AST_CAPTURE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !sync_req |-> ($stable(sync_vaddr) && $stable(sync_syndrome))) else $error("capture moved"); // R8

    AST_STICKY_BITS: assert property (@(posedge clk) disable iff (rst)
        (($past(async_status) & ~async_status) != '0) |-> $past(clr_valid))
        else $error("status bit dropped without clear"); // R9

    AST_STATUS_NEEDS_FAULT: assert property (@(posedge clk) disable iff (rst)
        ((async_status & ~$past(async_status)) != '0) |-> $past(flt_valid))
        else $error("status bit set without failure"); // R6

    AST_ONE_BIT_PER_FAULT: assert property (@(posedge clk) disable iff (rst)
        $countones(async_status & ~$past(async_status)) <= 1) else $error("two bits set at once"); // R6
endmodule

bind tcf_fault_ctrl tcf_fault_ctrl_chk #(
    .ADDR_W(ADDR_W), .CTRL_W(CTRL_W), .NUM_LVL(NUM_LVL), .LVL_W(LVL_W)
) u_chk (.*);

// File: tb/tb_tcf_fault_ctrl.sv
module tb_tcf_fault_ctrl;
    localparam int ADDR_W  = 64;
    localparam int CTRL_W  = 64;
    localparam int NUM_LVL = 4;
    localparam int LVL_W   = 2;
    localparam int ST_W    = 2*NUM_LVL;

    typedef struct packed {
        logic              req;
        logic [6:0]        syn;
        logic [ADDR_W-1:0] vaddr;
        logic [ST_W-1:0]   st;
    } snap_t;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              flt_valid = 1'b0;
    logic [ADDR_W-1:0] flt_addr = '0;
    logic              flt_is_store = 1'b0;
    logic              flt_unpriv = 1'b0;
    logic              flt_two_range = 1'b0;
    logic [LVL_W-1:0]  flt_level = '0;
    logic [CTRL_W-1:0] ctrl_word = '0;
    logic              clr_valid = 1'b0;
    logic [LVL_W-1:0]  clr_level = '0;
    logic [1:0]        clr_mask = '0;
    logic              sync_req;
    logic [6:0]        sync_syndrome;
    logic [ADDR_W-1:0] sync_vaddr;
    logic [ST_W-1:0]   async_status;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    snap_t exp_q[$];
    string tag_q[$];

    snap_t model;

    always #10 clk = ~clk;

    tcf_fault_ctrl #(.ADDR_W(ADDR_W), .CTRL_W(CTRL_W), .NUM_LVL(NUM_LVL)) dut (
        .clk(clk), .rst(rst), .flt_valid(flt_valid), .flt_addr(flt_addr),
        .flt_is_store(flt_is_store), .flt_unpriv(flt_unpriv), .flt_two_range(flt_two_range),
        .flt_level(flt_level), .ctrl_word(ctrl_word), .clr_valid(clr_valid),
        .clr_level(clr_level), .clr_mask(clr_mask), .sync_req(sync_req),
        .sync_syndrome(sync_syndrome), .sync_vaddr(sync_vaddr), .async_status(async_status)
    );

    function automatic logic [63:0] mk_ctrl(input logic [1:0] priv_m, input logic [1:0] unpriv_m);
        logic [63:0] c;
        c = 64'hF0F0_0000_0000_0F0F;
        c[41:40] = priv_m;
        c[39:38] = unpriv_m;
        return c;
    endfunction

    task automatic compare(input snap_t e, input string tag);
        snap_t a;
        a = '{req: sync_req, syn: sync_syndrome, vaddr: sync_vaddr, st: async_status};
        n_cmp++;
        if (a !== e) begin
            n_bad++;
            $display("FAIL %s: actual req=%0b syn=%h vaddr=%h st=%b expected req=%0b syn=%h vaddr=%h st=%b",
                     tag, a.req, a.syn, a.vaddr, a.st, e.req, e.syn, e.vaddr, e.st);
        end
    endtask

    // driver: one operation per cycle, expected result pushed to the scoreboard
    task automatic op(input bit fv, input logic [63:0] addr, input bit store, input bit unpriv,
                      input bit two, input int lvl, input logic [63:0] ctrl,
                      input bit cv, input int clvl, input logic [1:0] cmask, input string tag);
        logic [1:0] m;
        bit do_s, do_a;
        @(negedge clk);
        flt_valid = fv; flt_addr = addr; flt_is_store = store; flt_unpriv = unpriv;
        flt_two_range = two; flt_level = LVL_W'(lvl); ctrl_word = ctrl;
        clr_valid = cv; clr_level = LVL_W'(clvl); clr_mask = cmask;
        m = unpriv ? ctrl[39:38] : ctrl[41:40];
        do_s = 1'b0; do_a = 1'b0;
        if (fv) begin
            case (m)
                2'd1: do_s = 1'b1;
                2'd2: do_a = 1'b1;
                2'd3: begin do_a = store; do_s = !store; end
                default: ;
            endcase
        end
        if (cv) model.st[2*clvl +: 2] = model.st[2*clvl +: 2] & ~cmask;
        if (do_a) begin
            if (two && addr[55]) model.st[2*lvl+1] = 1'b1;
            else                 model.st[2*lvl]   = 1'b1;
        end
        model.req = do_s;
        if (do_s) begin
            model.vaddr = addr;
            model.syn   = {store, 6'h11};
        end
        exp_q.push_back(model);
        tag_q.push_back(tag);
    endtask

    task automatic idle(input string tag);
        op(0, 64'h0, 0, 0, 0, 0, 64'h0, 0, 0, 2'b00, tag);
    endtask

    // monitor: pops and compares just after each edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (exp_q.size() > 0) compare(exp_q.pop_front(), tag_q.pop_front());
        end
    end

    initial begin
        int cyc;
        cyc = 0;
        while (!done && cyc < 5000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        model = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        compare('0, "R10 reset state");

        // R2: policy 0 ignores loads and stores
        op(1, 64'h0000_0000_0000_1000, 0, 0, 0, 0, mk_ctrl(2'd0, 2'd0), 0, 0, 2'b00, "R2 ignore load");
        op(1, 64'h0080_0000_0000_1010, 1, 0, 1, 1, mk_ctrl(2'd0, 2'd0), 0, 0, 2'b00, "R2 ignore store");
        // R3: policy 1 traps loads and stores
        op(1, 64'h0000_0000_0000_2000, 0, 0, 0, 0, mk_ctrl(2'd1, 2'd0), 0, 0, 2'b00, "R3 trap load");
        op(1, 64'h0000_0000_0000_2040, 1, 0, 0, 0, mk_ctrl(2'd1, 2'd0), 0, 0, 2'b00, "R3 trap store back-to-back");
        idle("R7 single pulse");
        idle("R8 hold while idle");
        // R1: field selection by privilege
        op(1, 64'h0000_0000_0000_3000, 0, 1, 0, 0, mk_ctrl(2'd1, 2'd2), 0, 0, 2'b00, "R1 unpriv field");
        op(1, 64'h0000_0000_0000_3010, 0, 0, 0, 0, mk_ctrl(2'd0, 2'd1), 0, 0, 2'b00, "R1 priv field");
        op(1, 64'h0000_0000_0000_3020, 1, 1, 0, 0, mk_ctrl(2'd2, 2'd1), 0, 0, 2'b00, "R1 unpriv trap");
        // R4 / R6: flag policy and bit-55 selection
        op(1, 64'h0080_0000_0000_4000, 0, 0, 1, 1, mk_ctrl(2'd2, 2'd0), 0, 0, 2'b00, "R4 R6 upper range");
        op(1, 64'h0080_0000_0000_4010, 1, 0, 0, 1, mk_ctrl(2'd2, 2'd0), 0, 0, 2'b00, "R6 single range bit0");
        op(1, 64'h0000_0000_0000_4020, 0, 0, 1, 2, mk_ctrl(2'd2, 2'd0), 0, 0, 2'b00, "R6 low half level2");
        op(1, 64'h0080_0000_0000_4030, 1, 1, 1, 3, mk_ctrl(2'd0, 2'd2), 0, 0, 2'b00, "R6 level3 accumulate");
        idle("R8 async keeps capture");
        // R5: mixed policy
        op(1, 64'h0000_0000_0000_5000, 1, 0, 0, 0, mk_ctrl(2'd3, 2'd0), 0, 0, 2'b00, "R5 mixed store flags");
        op(1, 64'h0080_0000_0000_5010, 0, 0, 1, 0, mk_ctrl(2'd3, 2'd0), 0, 0, 2'b00, "R5 mixed load traps");
        op(1, 64'h0080_0000_0000_5020, 1, 1, 1, 0, mk_ctrl(2'd0, 2'd3), 0, 0, 2'b00, "R5 mixed store upper");
        idle("R7 pulse ends");
        // R9: clear and collision
        op(0, 64'h0, 0, 0, 0, 0, 64'h0, 1, 1, 2'b01, "R9 clear level1 bit0");
        op(1, 64'h0080_0000_0000_6000, 0, 0, 1, 1, mk_ctrl(2'd2, 2'd0), 1, 1, 2'b10, "R9 set wins over clear");
        op(1, 64'h0000_0000_0000_6010, 1, 0, 0, 2, mk_ctrl(2'd2, 2'd0), 1, 3, 2'b11, "R9 clear other level");
        op(0, 64'h0, 0, 0, 0, 0, 64'h0, 1, 0, 2'b11, "R9 clear level0");
        op(1, 64'h0000_0000_0000_7000, 0, 0, 0, 2, mk_ctrl(2'd0, 2'd0), 1, 2, 2'b01, "R2 R9 ignored fault no set");
        idle("R8 final hold");
        idle("final idle");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule